// File: doc/BRIEF.md
# Flash controller event status and interrupt unit

This block keeps the event status of a flash memory controller and turns it into one interrupt line. Pulses from the command sequencer, the data port and the error-correction checker each set a sticky status flag. Software clears flags by writing ones to the status register. A per-event mask sits in the low bits of the control register, and a mask bit set to 1 silences its source. The interrupt is the registered OR of every flag that is pending and not masked.

The control register also holds the run bit. A command starts when software writes the control register with run set while run is clear. That write also raises the command-word request flag, so the command words can be loaded. The sequencer clears run when the command finishes. If it never does, software writes the control register with run clear and then wipes the status.

The controller-ready flag tracks an input level and cannot be written. Software polls it to learn when the device is ready.

Top module: `flash_evt_status`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 and the interrupt is low.
- R2: A one-cycle pulse on event input k sets status bit k (k in 0..11) on that clock edge, and the bit stays set after the pulse ends. Status bit layout: 0 command-word request, 1 read-data request, 2 write-data request, 3 single-bit ECC error, 4 double-bit ECC error, 5/6 bad block on select 1/0, 7/8 command done on select 1/0, 9/10 page done on select 1/0, 11 flash ready.
- R3: A status write clears each bit 11:0 whose written data bit is 1 and leaves the other bits alone. Writing 0xFFF clears all twelve.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The interrupt is high exactly one cycle after some status bit k in 11:0 is set while control bit k is 0. A control bit k of 1 keeps source k from raising the interrupt. Status bit 12 never raises the interrupt.
- R6: Writing the control register with bit 28 (run) set while run is clear sets run and sets status bit 0 on the same edge.
- R7: A pulse on the run-done input clears run. Writing the control register with bit 28 clear also clears run, and the other control bits keep the written values.
- R8: Status bit 12 shows the controller-ready input as of the last clock edge. A write of 1 to status bit 12 has no effect.
- R9: The control register reads back the full written word. After a mask change, the interrupt takes the new mask into account one cycle later.
- R10: Writing the control register with run set while run is already set does not raise status bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 12 | One-cycle event pulses, one per status bit 11:0 |
| ctrl_ready_i | input | 1 | Controller-ready level, shown in status bit 12 |
| run_done_i | input | 1 | Pulse from the sequencer that clears run |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| ctrl_o | output | 32 | Control register contents |
| stat_o | output | 32 | Status register contents; bits 31:13 read 0 |
| run_o | output | 1 | Run bit |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions assume three things about the inputs:
- Event inputs are single-cycle pulses.
- `run_done_i` is raised only while a command is running.
- When a control write and a run-done pulse coincide, the write decides the run bit, and the run-done property leaves those cycles out.

The stimulus drives every input on the falling edge. It raises run-done only after a run start, and it holds the ready input steady across each status read it checks. Clear-versus-set collisions and start writes made while already running are produced on purpose, so that the priority and edge-detect rules are exercised.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned EVT_N     = 12;
  localparam int unsigned CMDREQ_IX = 0;
  localparam int unsigned READY_IX  = EVT_N;
  localparam int unsigned RUN_IX    = 28;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } wr_target_e;
endpackage

// File: rtl/flash_evt_ctrl.sv
module flash_evt_ctrl #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned RUN_IX = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             run_done,
  output logic [REG_W-1:0] ctrl_q,
  output logic             start_pulse
);
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_en;

  // Clock enable: either a register write or a completion from the sequencer.
  assign ctrl_en     = wr_ctrl | run_done;
  assign start_pulse = wr_ctrl & wdata[RUN_IX] & ~ctrl_q[RUN_IX];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = wdata;            // a software write decides run over a completion
    end else if (run_done) begin
      ctrl_d[RUN_IX] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/flash_evt_flags.sv
module flash_evt_flags #(
  parameter int unsigned EVT_N     = 12,
  parameter int unsigned CMDREQ_IX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] ev,
  input  logic             start_pulse,
  input  logic             wr_stat,
  input  logic [EVT_N-1:0] clr_bits,
  input  logic             ready_lvl,
  output logic [EVT_N-1:0] flag_q,
  output logic             ready_q
);
  logic [EVT_N-1:0] flag_d;

  for (genvar k = 0; k < EVT_N; k++) begin : g_flag
    logic set_k;
    logic clr_k;
    if (k == CMDREQ_IX) begin : g_cmdreq
      assign set_k = ev[k] | start_pulse;
    end else begin : g_plain
      assign set_k = ev[k];
    end
    assign clr_k = wr_stat & clr_bits[k];
    // A set in the same cycle as a clear wins.
    assign flag_d[k] = set_k | (flag_q[k] & ~clr_k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ready_q <= ready_lvl;
    end
  end
endmodule

// File: rtl/flash_evt_irq.sv
module flash_evt_irq #(
  parameter int unsigned EVT_N = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] flags,
  input  logic [EVT_N-1:0] mask_off,
  output logic             irq_q
);
  logic irq_d;

  // A mask bit of 1 disables its source.
  assign irq_d = |(flags & ~mask_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/flash_evt_status.sv
module flash_evt_status
  import flash_evt_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned NEV  = EVT_N,
  parameter int unsigned RUNB = RUN_IX
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_i,
  input  logic           ctrl_ready_i,
  input  logic           run_done_i,
  input  logic           wr_en_i,
  input  logic           wr_sel_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [W-1:0]   ctrl_o,
  output logic [W-1:0]   stat_o,
  output logic           run_o,
  output logic           irq_o
);
  localparam int unsigned PAD_W = W - NEV - 1;

  logic           wr_ctrl;
  logic           wr_stat;
  logic           start_pulse;
  logic [NEV-1:0] flag_q;
  logic           ready_q;

  assign wr_ctrl = wr_en_i & (wr_sel_i == SEL_CTRL);
  assign wr_stat = wr_en_i & (wr_sel_i == SEL_STAT);

  flash_evt_ctrl #(.REG_W(W), .RUN_IX(RUNB)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wdata       (wr_data_i),
    .run_done    (run_done_i),
    .ctrl_q      (ctrl_o),
    .start_pulse (start_pulse)
  );

  flash_evt_flags #(.EVT_N(NEV), .CMDREQ_IX(CMDREQ_IX)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev_i),
    .start_pulse (start_pulse),
    .wr_stat     (wr_stat),
    .clr_bits    (wr_data_i[NEV-1:0]),
    .ready_lvl   (ctrl_ready_i),
    .flag_q      (flag_q),
    .ready_q     (ready_q)
  );

  flash_evt_irq #(.EVT_N(NEV)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flag_q),
    .mask_off (ctrl_o[NEV-1:0]),
    .irq_q    (irq_o)
  );

  assign stat_o = {{PAD_W{1'b0}}, ready_q, flag_q};
  assign run_o  = ctrl_o[RUNB];
endmodule

// File: rtl/flash_evt_status_chk.sv
module flash_evt_status_chk #(
  parameter int unsigned W    = 32,
  parameter int unsigned NEV  = 12,
  parameter int unsigned RUNB = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] ev_i,
  input logic           ctrl_ready_i,
  input logic           run_done_i,
  input logic           wr_en_i,
  input logic           wr_sel_i,
  input logic [W-1:0]   wr_data_i,
  input logic [W-1:0]   ctrl_o,
  input logic [W-1:0]   stat_o,
  input logic           run_o,
  input logic           irq_o
);
  logic start_req;
  logic ctrl_wr;
  assign ctrl_wr   = wr_en_i && !wr_sel_i;
  assign start_req = ctrl_wr && wr_data_i[RUNB] && !run_o;

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((stat_o[NEV-1:0] & $past(ev_i)) == $past(ev_i))); // R2

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o[NEV-1:0] & ~ctrl_o[NEV-1:0]) == '0) |=> !irq_o); // R5

  AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (run_o && stat_o[0])); // R6

  AST_DONE_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done_i && !ctrl_wr) |=> !run_o); // R7

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(stat_o[NEV]) |-> (stat_o[NEV] == $past(ctrl_ready_i))); // R8

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == '0 && !start_req) |=> ((stat_o[NEV-1:0] & ~$past(stat_o[NEV-1:0])) == '0)); // R10
endmodule

bind flash_evt_status flash_evt_status_chk #(.W(W), .NEV(NEV), .RUNB(RUNB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_i         (ev_i),
  .ctrl_ready_i (ctrl_ready_i),
  .run_done_i   (run_done_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .ctrl_o       (ctrl_o),
  .stat_o       (stat_o),
  .run_o        (run_o),
  .irq_o        (irq_o)
);

// File: tb/tb_flash_evt_status.sv
module tb_flash_evt_status;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NEV = 12;

  typedef struct {
    logic [W-1:0] stat;
    logic [W-1:0] ctrl;
    logic         irq;
    string        req;
  } exp_t;

  logic           clk;
  logic           rst_n;
  logic [NEV-1:0] ev_i;
  logic           ctrl_ready_i;
  logic           run_done_i;
  logic           wr_en_i;
  logic           wr_sel_i;
  logic [W-1:0]   wr_data_i;
  logic [W-1:0]   ctrl_o;
  logic [W-1:0]   stat_o;
  logic           run_o;
  logic           irq_o;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  flash_evt_status dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ctrl_ready_i(ctrl_ready_i),
    .run_done_i(run_done_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .stat_o(stat_o),
    .run_o(run_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compares one queued expectation per falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (stat_o !== e.stat || ctrl_o !== e.ctrl || irq_o !== e.irq ||
            run_o !== e.ctrl[28]) begin
          n_bad++;
          $display("FAIL %s: stat=%h ctrl=%h irq=%b run=%b expected stat=%h ctrl=%h irq=%b",
                   e.req, stat_o, ctrl_o, irq_o, run_o, e.stat, e.ctrl, e.irq);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus, then queues the post-edge expectation.
  task automatic step(input logic [NEV-1:0] ev, input logic rdy, input logic wen,
                      input logic wsel, input logic [W-1:0] wd, input logic dn,
                      input logic [W-1:0] es, input logic [W-1:0] ec,
                      input logic ei, input string req);
    exp_t e;
    @(negedge clk);
    #2;
    ev_i = ev; ctrl_ready_i = rdy; wr_en_i = wen; wr_sel_i = wsel;
    wr_data_i = wd; run_done_i = dn;
    @(posedge clk);
    e.stat = es; e.ctrl = ec; e.irq = ei; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_i = '0; ctrl_ready_i = 1'b0; run_done_i = 1'b0;
    wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0000, 32'h0, 0, "R1");
    // R2 single-bit ECC event sets bit 3
    step(12'h008, 0, 0, 0, 32'h0, 0, 32'h0008, 32'h0, 0, "R2");
    // R5 irq one cycle later, mask 0
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0008, 32'h0, 1, "R5");
    // R9 mask bit 3
    step(12'h000, 0, 1, 0, 32'h8, 0, 32'h0008, 32'h8, 1, "R9");
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0008, 32'h8, 0, "R5");
    // R2 double-bit ECC and command done CS0
    step(12'h110, 0, 0, 0, 32'h0, 0, 32'h0118, 32'h8, 0, "R2");
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0118, 32'h8, 1, "R5");
    // R3 clear bit 4 only
    step(12'h000, 0, 1, 1, 32'h010, 0, 32'h0108, 32'h8, 1, "R3");
    // R4 set wins over clear on bit 8
    step(12'h100, 0, 1, 1, 32'h100, 0, 32'h0108, 32'h8, 1, "R4");
    // R3/R8 clear all incl. a write to bit 12 while ready rises
    step(12'h000, 1, 1, 1, 32'h1FFF, 0, 32'h1000, 32'h8, 1, "R8");
    // R5 bit 12 alone never interrupts
    step(12'h000, 1, 0, 0, 32'h0, 0, 32'h1000, 32'h8, 0, "R5");
    // Start sequence: control to 0, clear status, run
    step(12'h000, 1, 1, 0, 32'h0, 0, 32'h1000, 32'h0, 0, "R9");
    step(12'h000, 1, 1, 1, 32'hFFF, 0, 32'h1000, 32'h0, 0, "R3");
    step(12'h000, 1, 1, 0, 32'h1000_0FFE, 0, 32'h1001, 32'h1000_0FFE, 0, "R6");
    step(12'h000, 1, 0, 0, 32'h0, 0, 32'h1001, 32'h1000_0FFE, 1, "R5");
    step(12'h000, 1, 1, 1, 32'h001, 0, 32'h1000, 32'h1000_0FFE, 1, "R3");
    // R10 rewrite with run already set
    step(12'h000, 1, 1, 0, 32'h1000_0FFE, 0, 32'h1000, 32'h1000_0FFE, 0, "R10");
    // R7 completion clears run
    step(12'h000, 1, 0, 0, 32'h0, 1, 32'h1000, 32'h0000_0FFE, 0, "R7");
    step(12'h000, 1, 1, 0, 32'h1000_0FFF, 0, 32'h1001, 32'h1000_0FFF, 0, "R6");
    // R7 software abort
    step(12'h000, 1, 1, 0, 32'h0000_0FFF, 0, 32'h1001, 32'h0000_0FFF, 0, "R7");
    step(12'h000, 0, 1, 1, 32'hFFF, 0, 32'h0000, 32'h0000_0FFF, 0, "R3");
    // R5 all events, all masked
    step(12'hFFF, 0, 0, 0, 32'h0, 0, 32'h0FFF, 32'h0000_0FFF, 0, "R2");
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0FFF, 32'h0000_0FFF, 0, "R5");
    // R9 unmask bit 11
    step(12'h000, 0, 1, 0, 32'h7FF, 0, 32'h0FFF, 32'h0000_07FF, 0, "R9");
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0FFF, 32'h0000_07FF, 1, "R9");
    step(12'h000, 0, 0, 0, 32'h0, 0, 32'h0FFF, 32'h0000_07FF, 1, "R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule